// File: doc/BRIEF.md
# Carryless Multiply Modulo a CRC Polynomial

This block multiplies two 16-bit polynomials over GF(2) and reduces the product modulo a degree-16 CRC generator. It returns a 16-bit remainder. An AND/XOR array forms the 31-bit carryless product. No long-division loop follows. The reduction estimates the quotient with a fixed reciprocal of the generator, multiplies that estimate back by the generator, and XORs it away.

CRC engines use the block to advance a register over runs of zero bits by multiplying with a power of x. They also use it to combine partial checksums, or to feed message bytes in reverse order. The generator and its reciprocal are parameters that are fixed when the block is built. A parameter selects an optional output register, which adds one cycle of latency.

Top module: `clmul_mod_poly`

## Requirements
- R1: `res_o` equals the GF(2) product of `a_i` and `b_i` reduced modulo the generator 0x11021 (x^16 term explicit, reciprocal 0x8898), for arbitrary operands.
- R2: When either operand is 0, `res_o` is 0.
- R3: Multiplying by the polynomial 1 returns the other operand unchanged (a=1 gives b, b=1 gives a).
- R4: With `a_i` = 2 (the polynomial x), `res_o` is `b_i` shifted left by one. When bit 15 of `b_i` is 1, the result is additionally XORed with 0x1021.
- R5: The result does not depend on operand order: swapping `a_i` and `b_i` gives the same `res_o`.
- R6: With `OUT_REG`=1 (the default), `res_o` takes the result for the operands present at a rising clock edge just after that edge. It holds that value until the next edge.
- R7: While `rst_ni` is low, `res_o` is 0 (registered variant).
- R8: All-ones operands (0xFFFF), and the pairs 0xFFFF with 1 and 0xFFFF with 0x8000, give the fully reduced remainder.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | 16 | First polynomial operand, bit k is the x^k coefficient |
| b_i | input | 16 | Second polynomial operand, bit k is the x^k coefficient |
| res_o | output | 16 | Remainder of the carryless product modulo the generator |

## Verification
In the default registered build, each result is due exactly one rising edge after its operands are applied, and there is no other delay. The bench changes operands on the falling edge. It samples `res_o` one nanosecond after the following rising edge, where the new value must be present. In the latency scenario it also samples just after the operand change, where the previous result must still be held. Expected values come from a 16-step shift-and-XOR model that scans `b` from its top bit. This model shares nothing with the reciprocal-based datapath.

// File: rtl/clmul_pkg.sv
package clmul_pkg;
  localparam int unsigned OP_W = 16;
  // generator with x^16 explicit, and floor(x^31 / generator)
  localparam logic [OP_W:0]   GEN_POLY = 17'h11021;
  localparam logic [OP_W-1:0] GEN_INV  = 16'h8898;
endpackage

// File: rtl/gf2_mul_array.sv
// Carryless AND/XOR product, emitting only bits LO .. LO+OW-1.
module gf2_mul_array #(
  parameter int unsigned AW = 16,
  parameter int unsigned BW = 16,
  parameter int unsigned LO = 0,
  parameter int unsigned OW = AW + BW - 1
) (
  input  logic [AW-1:0] a_i,
  input  logic [BW-1:0] b_i,
  output logic [OW-1:0] p_o
);
  for (genvar k = 0; k < OW; k++) begin : g_bit
    localparam int K = int'(LO) + k;
    logic [AW-1:0] term;
    for (genvar i = 0; i < AW; i++) begin : g_term
      if ((K - i) >= 0 && (K - i) < int'(BW)) begin : g_on
        assign term[i] = a_i[i] & b_i[K-i];
      end else begin : g_off
        assign term[i] = 1'b0;
      end
    end
    // reduction XOR maps to a balanced tree
    assign p_o[k] = ^term;
  end
endmodule

// File: rtl/gf2_barrett_reduce.sv
// Reduce a (2W-1)-bit carryless product modulo a degree-W generator.
module gf2_barrett_reduce #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] POLY_LO = 16'h1021,
  parameter logic [W-1:0] INV = 16'h8898
) (
  input  logic [2*W-2:0] prod_i,
  output logic [W-1:0]   rem_o
);
  localparam int unsigned HW = W - 1;

  logic [HW-1:0] prod_hi;
  logic [HW-1:0] quot;
  logic [W-1:0]  qp_lo;

  assign prod_hi = prod_i[2*W-2:W];

  // quotient = (hi * INV) >> (W-1); only those bits are built
  gf2_mul_array #(.AW(HW), .BW(W), .LO(W-1), .OW(HW)) u_quot (
    .a_i(prod_hi), .b_i(INV), .p_o(quot)
  );

  // only the low W bits of quot*P survive; x^W term of P cannot reach them
  gf2_mul_array #(.AW(HW), .BW(W), .LO(0), .OW(W)) u_back (
    .a_i(quot), .b_i(POLY_LO), .p_o(qp_lo)
  );

  assign rem_o = prod_i[W-1:0] ^ qp_lo;
endmodule

// File: rtl/clmul_mod_poly.sv
module clmul_mod_poly #(
  parameter int unsigned W       = clmul_pkg::OP_W,
  parameter logic [W:0]  POLY    = clmul_pkg::GEN_POLY,
  parameter logic [W-1:0] INV    = clmul_pkg::GEN_INV,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  localparam int unsigned PW = 2 * W - 1;

  logic [PW-1:0] prod;
  logic [W-1:0]  rem;

  gf2_mul_array #(.AW(W), .BW(W), .LO(0), .OW(PW)) u_prod (
    .a_i(a_i), .b_i(b_i), .p_o(prod)
  );

  gf2_barrett_reduce #(.W(W), .POLY_LO(POLY[W-1:0]), .INV(INV)) u_red (
    .prod_i(prod), .rem_o(rem)
  );

  if (OUT_REG) begin : g_reg
    logic [W-1:0] res_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) res_q <= '0;
      else         res_q <= rem;
    end
    assign res_o = res_q;
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk_i ^ rst_ni;
    assign res_o = rem;
  end
endmodule

// File: rtl/clmul_mod_poly_chk.sv
module clmul_mod_poly_chk #(
  parameter int unsigned W       = 16,
  parameter logic [W:0]  POLY    = 17'h11021,
  parameter bit          OUT_REG = 1'b1
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [W-1:0] res_o
);
  logic live_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  if (OUT_REG) begin : g_reg
    p_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (a_i == '0 || b_i == '0) |=> res_o == '0);
    p_ident_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (a_i == W'(1)) |=> res_o == $past(b_i));
    p_mulx_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (a_i == W'(2)) |=> res_o == ({$past(b_i[W-2:0]), 1'b0}
                                   ^ ($past(b_i[W-1]) ? POLY[W-1:0] : '0)));
    p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live_q && $stable(a_i) && $stable(b_i)) |=> $stable(res_o));
    always @(negedge clk_i) begin
      if (!rst_ni) p_reset_r7: assert (res_o == '0);
    end
  end else begin : g_comb
    p_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (a_i == '0 || b_i == '0) |-> res_o == '0);
    p_ident_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (a_i == W'(1)) |-> res_o == b_i);
    p_mulx_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (a_i == W'(2)) |-> res_o == ({b_i[W-2:0], 1'b0}
                                   ^ (b_i[W-1] ? POLY[W-1:0] : '0)));
    p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live_q && $stable(a_i) && $stable(b_i)) |-> $stable(res_o));
  end
endmodule

bind clmul_mod_poly clmul_mod_poly_chk #(.W(W), .POLY(POLY), .OUT_REG(OUT_REG)) u_chk (.*);

// File: tb/clmul_mod_poly_bench.sv
`timescale 1ns/1ps
module clmul_mod_poly_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] a = '0;
  logic [15:0] b = '0;
  logic [15:0] res;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  clmul_mod_poly u_clmul_mod_poly (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .res_o(res)
  );

  // shift-and-XOR model, scanning b from its top bit
  function automatic logic [15:0] ref_mul(logic [15:0] x, logic [15:0] y);
    logic [15:0] pd = '0;
    for (int i = 15; i >= 0; i--) begin
      pd = {pd[14:0], 1'b0} ^ (pd[15] ? 16'h1021 : 16'h0000);
      if (y[i]) pd = pd ^ x;
    end
    return pd;
  endfunction

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%04h exp=%04h", req, got, exp);
    end
  endtask

  // apply at falling edge, sample 1 ns after the next rising edge
  task automatic apply(logic [15:0] x, logic [15:0] y);
    @(negedge clk);
    a = x; b = y;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset_r7();
    a = 16'h1234; b = 16'h5678;
    repeat (3) @(posedge clk);
    #1 check("R7 reset", res, 16'h0000);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic t_zero_r2();
    apply(16'h0000, 16'hBEEF); check("R2 a=0", res, 16'h0000);
    apply(16'hBEEF, 16'h0000); check("R2 b=0", res, 16'h0000);
    apply(16'h0000, 16'h0000); check("R2 both", res, 16'h0000);
  endtask

  task automatic t_ident_r3();
    apply(16'h0001, 16'hA5C3); check("R3 a=1", res, 16'hA5C3);
    apply(16'h7E81, 16'h0001); check("R3 b=1", res, 16'h7E81);
  endtask

  task automatic t_mulx_r4();
    apply(16'h0002, 16'h4001); check("R4 no wrap", res, 16'h8002);
    apply(16'h0002, 16'h8000); check("R4 wrap", res, 16'h1021);
    apply(16'h0002, 16'hC003); check("R4 wrap mixed", res, 16'h9027);
  endtask

  task automatic t_random_r1();
    for (int k = 0; k < 200; k++) begin
      logic [15:0] x = 16'($urandom);
      logic [15:0] y = 16'($urandom);
      apply(x, y);
      check("R1 random", res, ref_mul(x, y));
    end
    apply(16'h0100, 16'h0100); check("R1 x^16", res, 16'h1021);
  endtask

  task automatic t_swap_r5();
    for (int k = 0; k < 20; k++) begin
      logic [15:0] x = 16'($urandom);
      logic [15:0] y = 16'($urandom);
      logic [15:0] r1;
      apply(x, y); r1 = res;
      apply(y, x); check("R5 swap", res, r1);
    end
  endtask

  task automatic t_ones_r8();
    apply(16'hFFFF, 16'hFFFF); check("R8 ffff*ffff", res, ref_mul(16'hFFFF, 16'hFFFF));
    apply(16'hFFFF, 16'h0001); check("R8 ffff*1", res, 16'hFFFF);
    apply(16'hFFFF, 16'h8000); check("R8 ffff*x15", res, ref_mul(16'hFFFF, 16'h8000));
  endtask

  task automatic t_latency_r6();
    logic [15:0] prev;
    apply(16'h1357, 16'h2468);
    prev = ref_mul(16'h1357, 16'h2468);
    check("R6 first", res, prev);
    @(negedge clk);
    a = 16'h9ABC; b = 16'hDEF0;
    #1 check("R6 held before edge", res, prev);
    @(posedge clk);
    #1 check("R6 one edge later", res, ref_mul(16'h9ABC, 16'hDEF0));
    @(posedge clk);
    #1 check("R6 stays", res, ref_mul(16'h9ABC, 16'hDEF0));
  endtask

  initial begin
    t_reset_r7();
    t_zero_r2();
    t_ident_r3();
    t_mulx_r4();
    t_random_r1();
    t_swap_r5();
    t_ones_r8();
    t_latency_r6();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule